// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset Control

This block moves data words from one clock domain to another. Words go in on the write clock and come out, in the order they were written, on an unrelated read clock. Each side keeps a binary pointer. The pointer is turned into Gray code before it crosses to the other side, where two flip-flop stages resynchronize it. The write side works out a full flag and a write-side occupancy count. The read side works out an empty flag and a read-side occupancy count. Because the pointers take time to cross, each count can lag behind the true occupancy, but only in the safe direction. The read port is first-word fall-through: whenever the FIFO is not empty, the oldest stored word is already on the read data output.

Reset has two modes, chosen by a parameter. In the default mode the block takes one asynchronous reset and builds a separate reset for each domain. Each domain reset asserts at once and releases only after two edges of that domain's clock. A busy output stays high while either domain is still held in reset. This busy output is not timed to either clock, so a user must synchronize it before sampling it. In the other mode the block ignores the asynchronous reset and the busy output. It takes two reset inputs instead, each already synchronous to its own clock. DEPTH must be a power of two and at least 4.

Top module: `cdc_fifo`

## Requirements
- R1: While the active reset is high (arst when INT_RST=1), both pointers are cleared. empty reads 1, full reads 0, wr_count and rd_count read 0, and rst_busy reads 1. A reset in the middle of operation discards all stored words.
- R2: With INT_RST=1, rst_busy stays 1 after arst falls until the write domain has seen two wclk rising edges and the read domain has seen two rclk rising edges. After that it reads 0.
- R3: Words come out of rd_data in the exact order they were accepted. No word is lost or duplicated, including when both sides are active at the same time and under backpressure.
- R4: A write is accepted at a wclk rising edge only when wr_req=1 and full=0. full reads 1 once DEPTH words are held. A write attempted while full leaves the contents unchanged.
- R5: A read is accepted at an rclk rising edge only when rd_req=1 and empty=0. A read attempted while empty does not move the read pointer. The next word written is the next word delivered.
- R6: wr_count equals the accepted writes minus the reads that have become visible in the write domain. It never exceeds DEPTH, it equals DEPTH exactly when full=1, and it settles to the true occupancy once reads stop.
- R7: rd_count equals the writes that have become visible in the read domain minus the accepted reads. It is 0 exactly when empty=1, and it settles to the true occupancy once writes stop.
- R8: Whenever empty=0, rd_data shows the oldest stored word with no read request needed (first-word fall-through). Asserting rd_req moves the output to the next word at the following rclk rising edge.
- R9: With INT_RST=0, wr_rst_s resets the write side and rd_rst_s resets the read side, arst has no effect, and rst_busy is tied to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst | input | 1 | Asynchronous reset, active high (used when INT_RST=1) |
| wr_rst_s | input | 1 | Write-domain reset, already synchronous to wclk (used when INT_RST=0) |
| rd_rst_s | input | 1 | Read-domain reset, already synchronous to rclk (used when INT_RST=0) |
| rst_busy | output | 1 | High while either domain is in reset. Not timed to either clock. |
| wclk | input | 1 | Write clock |
| wr_req | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| full | output | 1 | FIFO holds DEPTH words |
| wr_count | output | $clog2(DEPTH)+1 | Write-side occupancy |
| rclk | input | 1 | Read clock |
| rd_req | input | 1 | Read request (consumes the word on rd_data) |
| rd_data | output | DW | Oldest stored word |
| empty | output | 1 | FIFO holds no words |
| rd_count | output | $clog2(DEPTH)+1 | Read-side occupancy |

## Verification
The assertions check the following on every clock edge of their domain:
- A full or empty FIFO never moves its pointer.
- Each Gray pointer changes at most one bit per step.
- full agrees with wr_count at DEPTH, and empty agrees with rd_count at zero.
- Neither count goes past DEPTH.
- rst_busy covers every cycle in which a domain is still held in reset.

The bench scenarios cover the rest:
- End-to-end ordering through the crossing, with both sides running at once under backpressure.
- Counts settling to the true occupancy once the other side goes quiet.
- The exact release of rst_busy.
- A reset in the middle of a transfer throwing away stored words.
- The externally reset variant.

// File: rtl/cdc_fifo_pkg.sv
package cdc_fifo_pkg;

    // Upper bound on pointer width handled by the Gray helpers.
    localparam int PTR_MAX = 32;
    // Flip-flop stages in every synchronizer of the block.
    localparam int SYNC_STAGES = 2;

    typedef logic [PTR_MAX-1:0] ptr_raw_t;

    // Per-domain reset pair.
    typedef struct packed {
        logic rd;
        logic wr;
    } dom_rst_t;

    function automatic ptr_raw_t to_gray(ptr_raw_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_raw_t from_gray(ptr_raw_t g);
        ptr_raw_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/cdc_fifo_rst.sv
module cdc_fifo_rst
    import cdc_fifo_pkg::*;
#(
    parameter bit INT_RST = 1'b1
) (
    input  logic     wclk,
    input  logic     rclk,
    input  logic     arst,
    input  logic     wr_rst_s,
    input  logic     rd_rst_s,
    output dom_rst_t dom_rst,
    output logic     busy
);

    logic [1:0] clks;
    logic [1:0] rst_vec;

    assign clks = {rclk, wclk};

    generate
        if (INT_RST) begin : g_int
            // One stretcher per domain: asserts at once, releases after SYNC_STAGES edges.
            for (genvar d = 0; d < 2; d++) begin : g_dom
                logic [SYNC_STAGES-1:0] sh;
                always_ff @(posedge clks[d] or posedge arst) begin
                    if (arst) sh <= '1;
                    else      sh <= {sh[SYNC_STAGES-2:0], 1'b0};
                end
                assign rst_vec[d] = sh[SYNC_STAGES-1];
            end
            assign busy = |rst_vec;
            logic unused_ext;
            assign unused_ext = wr_rst_s ^ rd_rst_s;
        end else begin : g_ext
            assign rst_vec = {rd_rst_s, wr_rst_s};
            assign busy    = 1'b0;
            logic unused_arst;
            assign unused_arst = arst;
        end
    endgenerate

    assign dom_rst.wr = rst_vec[0];
    assign dom_rst.rd = rst_vec[1];

endmodule

// File: rtl/cdc_fifo_sync.sv
module cdc_fifo_sync
    import cdc_fifo_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [SYNC_STAGES];

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk or posedge rst) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage[SYNC_STAGES-1];

endmodule

// File: rtl/cdc_fifo_ram.sv
module cdc_fifo_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/cdc_fifo_wside.sv
module cdc_fifo_wside
    import cdc_fifo_pkg::*;
#(
    parameter int AW  = 4,
    localparam int PW = AW + 1
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wr_req,
    input  logic [PW-1:0] rgray_s,
    output logic          full,
    output logic [PW-1:0] count,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray
);

    logic [PW-1:0] bin_q, bin_n, gray_n, rbin_s;

    // Full: the other side's pointer is one lap behind (top two Gray bits inverted).
    assign full   = (wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    assign push   = wr_req && !full;
    assign bin_n  = bin_q + PW'(push);
    assign gray_n = PW'(to_gray(ptr_raw_t'(bin_n)));
    assign rbin_s = PW'(from_gray(ptr_raw_t'(rgray_s)));
    assign count  = bin_q - rbin_s;
    assign waddr  = bin_q[AW-1:0];

    always_ff @(posedge wclk or posedge wrst) begin
        if (wrst) begin
            bin_q <= '0;
            wgray <= '0;
        end else begin
            bin_q <= bin_n;
            wgray <= gray_n;
        end
    end

endmodule

// File: rtl/cdc_fifo_rside.sv
module cdc_fifo_rside
    import cdc_fifo_pkg::*;
#(
    parameter int AW  = 4,
    localparam int PW = AW + 1
) (
    input  logic          rclk,
    input  logic          rrst,
    input  logic          rd_req,
    input  logic [PW-1:0] wgray_s,
    output logic          empty,
    output logic [PW-1:0] count,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray
);

    logic [PW-1:0] bin_q, bin_n, gray_n, wbin_s;
    logic          pop;

    assign empty  = (rgray == wgray_s);
    assign pop    = rd_req && !empty;
    assign bin_n  = bin_q + PW'(pop);
    assign gray_n = PW'(to_gray(ptr_raw_t'(bin_n)));
    assign wbin_s = PW'(from_gray(ptr_raw_t'(wgray_s)));
    assign count  = wbin_s - bin_q;
    assign raddr  = bin_q[AW-1:0];

    always_ff @(posedge rclk or posedge rrst) begin
        if (rrst) begin
            bin_q <= '0;
            rgray <= '0;
        end else begin
            bin_q <= bin_n;
            rgray <= gray_n;
        end
    end

endmodule

// File: rtl/cdc_fifo.sv
module cdc_fifo
    import cdc_fifo_pkg::*;
#(
    parameter int DW      = 8,
    parameter int DEPTH   = 16,
    parameter bit INT_RST = 1'b1
) (
    input  logic                     arst,
    input  logic                     wr_rst_s,
    input  logic                     rd_rst_s,
    output logic                     rst_busy,
    input  logic                     wclk,
    input  logic                     wr_req,
    input  logic [DW-1:0]            wr_data,
    output logic                     full,
    output logic [$clog2(DEPTH):0]   wr_count,
    input  logic                     rclk,
    input  logic                     rd_req,
    output logic [DW-1:0]            rd_data,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   rd_count
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    dom_rst_t      dom_rst;
    logic          wrst, rrst, push;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

    cdc_fifo_rst #(.INT_RST(INT_RST)) u_rst (
        .wclk(wclk), .rclk(rclk), .arst(arst),
        .wr_rst_s(wr_rst_s), .rd_rst_s(rd_rst_s),
        .dom_rst(dom_rst), .busy(rst_busy)
    );

    assign wrst = dom_rst.wr;
    assign rrst = dom_rst.rd;

    cdc_fifo_wside #(.AW(AW)) u_wside (
        .wclk(wclk), .wrst(wrst), .wr_req(wr_req), .rgray_s(rgray_s),
        .full(full), .count(wr_count), .push(push), .waddr(waddr), .wgray(wgray)
    );

    cdc_fifo_rside #(.AW(AW)) u_rside (
        .rclk(rclk), .rrst(rrst), .rd_req(rd_req), .wgray_s(wgray_s),
        .empty(empty), .count(rd_count), .raddr(raddr), .rgray(rgray)
    );

    cdc_fifo_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s)
    );

    cdc_fifo_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s)
    );

    cdc_fifo_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
        .wclk(wclk), .we(push), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(rd_data)
    );

endmodule

// File: rtl/cdc_fifo_chk.sv
module cdc_fifo_chk #(
    parameter int DEPTH   = 16,
    parameter bit INT_RST = 1'b1,
    localparam int PW     = $clog2(DEPTH) + 1
) (
    input logic          wclk,
    input logic          rclk,
    input logic          arst,
    input logic          wrst,
    input logic          rrst,
    input logic          rst_busy,
    input logic          full,
    input logic          empty,
    input logic [PW-1:0] wr_count,
    input logic [PW-1:0] rd_count,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray
);

    a_r4_no_overflow: assert property (@(posedge wclk) disable iff (wrst)
        full |=> $stable(wgray));

    a_r5_no_underflow: assert property (@(posedge rclk) disable iff (rrst)
        empty |=> $stable(rgray));

    a_r3_wgray_step: assert property (@(posedge wclk) disable iff (wrst)
        $countones(wgray ^ $past(wgray)) <= 1);

    a_r3_rgray_step: assert property (@(posedge rclk) disable iff (rrst)
        $countones(rgray ^ $past(rgray)) <= 1);

    a_r6_full_count: assert property (@(posedge wclk) disable iff (wrst)
        full == (wr_count == PW'(DEPTH)));

    a_r6_count_bound: assert property (@(posedge wclk) disable iff (wrst)
        wr_count <= PW'(DEPTH));

    a_r7_empty_count: assert property (@(posedge rclk) disable iff (rrst)
        empty == (rd_count == '0));

    a_r7_count_bound: assert property (@(posedge rclk) disable iff (rrst)
        rd_count <= PW'(DEPTH));

    generate
        if (INT_RST) begin : g_busy
            a_r2_busy_wr: assert property (@(posedge wclk) disable iff (arst)
                wrst |-> rst_busy);
            a_r2_busy_rd: assert property (@(posedge rclk) disable iff (arst)
                rrst |-> rst_busy);
        end
    endgenerate

endmodule

bind cdc_fifo cdc_fifo_chk #(.DEPTH(DEPTH), .INT_RST(INT_RST)) u_chk (
    .wclk(wclk), .rclk(rclk), .arst(arst), .wrst(wrst), .rrst(rrst),
    .rst_busy(rst_busy), .full(full), .empty(empty),
    .wr_count(wr_count), .rd_count(rd_count), .wgray(wgray), .rgray(rgray)
);

// File: tb/tb_cdc_fifo.sv
`timescale 1ns/1ps
module tb_cdc_fifo;

    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic wclk = 1'b0, rclk = 1'b0;
    always #5 wclk = ~wclk;
    always #8 rclk = ~rclk;

    logic          arst = 1'b1;
    logic          wr_req = 1'b0, rd_req = 1'b0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic          full, empty, rst_busy;
    logic [CW-1:0] wr_count, rd_count;

    logic          e_wrst = 1'b1, e_rrst = 1'b1;
    logic          e_wr_req = 1'b0, e_rd_req = 1'b0;
    logic [DW-1:0] e_wr_data = '0, e_rd_data;
    logic          e_full, e_empty, e_busy;
    logic [CW-1:0] e_wr_count, e_rd_count;

    int n_tests = 0, n_fail = 0;
    logic [DW-1:0] q [$];

    cdc_fifo #(.DW(DW), .DEPTH(DEPTH), .INT_RST(1'b1)) dut (
        .arst(arst), .wr_rst_s(1'b0), .rd_rst_s(1'b0), .rst_busy(rst_busy),
        .wclk(wclk), .wr_req(wr_req), .wr_data(wr_data), .full(full), .wr_count(wr_count),
        .rclk(rclk), .rd_req(rd_req), .rd_data(rd_data), .empty(empty), .rd_count(rd_count)
    );

    cdc_fifo #(.DW(DW), .DEPTH(DEPTH), .INT_RST(1'b0)) dut_ext (
        .arst(1'b0), .wr_rst_s(e_wrst), .rd_rst_s(e_rrst), .rst_busy(e_busy),
        .wclk(wclk), .wr_req(e_wr_req), .wr_data(e_wr_data), .full(e_full), .wr_count(e_wr_count),
        .rclk(rclk), .rd_req(e_rd_req), .rd_data(e_rd_data), .empty(e_empty), .rd_count(e_rd_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Driver: single write attempt, expected item queued only if accepted.
    task automatic push_word(input logic [DW-1:0] d);
        @(negedge wclk);
        wr_req  = 1'b1;
        wr_data = d;
        if (!full) q.push_back(d);
        @(negedge wclk);
        wr_req = 1'b0;
    endtask

    // Driver with backpressure.
    task automatic stream_write(input int n, input logic [DW-1:0] base);
        int i = 0;
        while (i < n) begin
            @(negedge wclk);
            if (!full) begin
                wr_req  = 1'b1;
                wr_data = base + DW'(i);
                q.push_back(wr_data);
                i++;
            end else begin
                wr_req = 1'b0;
            end
        end
        @(negedge wclk);
        wr_req = 1'b0;
    endtask

    // Monitor: compares the presented word, then consumes it.
    task automatic pop_check(input int n, input string req, input int stall);
        int k = 0;
        int cyc = 0;
        while (k < n) begin
            @(negedge rclk);
            cyc++;
            if (!empty && !(stall != 0 && (cyc % stall) == 0)) begin
                if (q.size() == 0) begin
                    chk(req, {24'h0, rd_data}, 32'hDEAD);
                end else begin
                    chk(req, {24'h0, rd_data}, {24'h0, q.pop_front()});
                end
                rd_req = 1'b1;
                k++;
            end else begin
                rd_req = 1'b0;
            end
        end
        @(negedge rclk);
        rd_req = 1'b0;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual hang expected finish");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge wclk);
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 wr_count", wr_count, 0);
        chk("R1 rd_count", rd_count, 0);
        chk("R1 busy", rst_busy, 1);

        // R2: busy release
        #2 arst = 1'b0;
        #1 chk("R2 busy right after release", rst_busy, 1);
        repeat (3) @(posedge wclk);
        repeat (3) @(posedge rclk);
        @(negedge wclk);
        chk("R2 busy released", rst_busy, 0);

        // R4/R6: fill to full, then an ignored write
        for (int i = 0; i < DEPTH; i++) push_word(DW'(8'h10 + i));
        chk("R4 full after DEPTH writes", full, 1);
        chk("R6 wr_count at full", wr_count, DEPTH);
        push_word(8'hEE);
        chk("R4 queue unchanged by write at full", q.size(), DEPTH);
        chk("R6 wr_count after rejected write", wr_count, DEPTH);

        // R7/R8: read side sees all words, oldest presented
        repeat (5) @(negedge rclk);
        chk("R7 rd_count full", rd_count, DEPTH);
        chk("R8 fall-through oldest word", rd_data, 8'h10);

        // R3: drain in order
        pop_check(DEPTH, "R3 order drain", 0);
        chk("R4 empty after DEPTH reads", empty, 1);
        chk("R7 rd_count drained", rd_count, 0);

        // R5: reads while empty are ignored
        @(negedge rclk);
        rd_req = 1'b1;
        repeat (3) @(negedge rclk);
        rd_req = 1'b0;
        push_word(8'h5A);
        repeat (5) @(negedge rclk);
        chk("R5 rd_count after empty reads", rd_count, 1);
        chk("R5 next word after empty reads", rd_data, 8'h5A);
        pop_check(1, "R5 drain", 0);

        // R6: write count settles
        repeat (5) @(negedge wclk);
        chk("R6 wr_count settled", wr_count, 0);

        // R3: concurrent traffic with backpressure and read stalls
        fork
            stream_write(3 * DEPTH, 8'h40);
            pop_check(3 * DEPTH, "R3 order concurrent", 3);
        join
        chk("R3 scoreboard empty", q.size(), 0);
        @(negedge rclk);
        chk("R3 empty after concurrent", empty, 1);

        // R1: reset in the middle of operation
        for (int i = 0; i < 5; i++) push_word(DW'(8'hA0 + i));
        repeat (4) @(negedge rclk);
        chk("R7 rd_count before mid reset", rd_count, 5);
        @(negedge wclk);
        arst = 1'b1;
        #1;
        chk("R1 mid reset empty", empty, 1);
        chk("R1 mid reset full", full, 0);
        chk("R1 mid reset wr_count", wr_count, 0);
        chk("R1 mid reset rd_count", rd_count, 0);
        chk("R1 mid reset busy", rst_busy, 1);
        q.delete();
        repeat (2) @(negedge wclk);
        arst = 1'b0;
        repeat (4) @(negedge rclk);
        chk("R1 still empty after mid reset", empty, 1);

        // R9: external reset variant
        chk("R9 ext empty in reset", e_empty, 1);
        chk("R9 ext busy tied low", e_busy, 0);
        @(negedge wclk) e_wrst = 1'b0;
        @(negedge rclk) e_rrst = 1'b0;
        @(negedge wclk);
        e_wr_req = 1'b1; e_wr_data = 8'h77;
        @(negedge wclk);
        e_wr_req = 1'b0;
        chk("R9 ext wr_count", e_wr_count, 1);
        repeat (5) @(negedge rclk);
        chk("R9 ext rd_count", e_rd_count, 1);
        chk("R9 ext rd_data", e_rd_data, 8'h77);
        @(negedge wclk) e_wrst = 1'b1;
        #1 chk("R9 ext wr reset clears count", e_wr_count, 0);
        chk("R9 ext busy still low", e_busy, 0);

        summary();
        $finish;
    end

endmodule